// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Byte Lanes and Collision Control

This block is a true dual-port memory. Two ports, A and B, share one clock, and each port can read and write on its own. Every data byte is stored with a ninth bit beside it, so a word is built from 9-bit lanes. Each port has one write enable per lane, so a write can change only some of the lanes.

Addresses, write data and write controls take effect only on the rising clock edge. Each port reads from the address it captured at the latest edge. One parameter decides whether the read value goes straight out from the array or passes through an output register that resets to zero.

A second parameter decides what a port returns in the cycle when the other port writes the address it is reading. It returns either the word as it was before that write, or an unknown value. In both cases the new word appears one cycle later. When both ports write one address on the same edge, port A wins.

Top module: `tdp_ram_bytepar`

## Requirements
- R1: A write takes effect on the rising edge where the port's write enable is high. A read returns the word at the address the port captured on the latest rising edge. There is no path from an input to the array or to an output that bypasses the clock edge.
- R2: When a port writes an address, its own output in the cycle after that edge shows the newly written lanes. This includes the case where the port reads and writes the same address at once.
- R3: When the collision parameter selects old data, and a port that is not writing captures the address the other port writes on the same edge, its output for that cycle is the word stored before the write.
- R4: When the collision parameter selects the undefined result, the reading port's output in the collision cycle carries no guarantee and is driven unknown. Once that cycle ends, the port reads the stored word again.
- R5: After a mixed-port collision, the reading port shows the newly written word in the next cycle, provided it keeps the same address.
- R6: Lane l of a word occupies bits [9l+8:9l], and write-enable bit l controls that lane alone. A write with only some lane enables set leaves the other lanes of the word unchanged.
- R7: Bit 9l+8 of each lane is the parity bit. It is stored and read back exactly as it was written. The block neither generates nor checks parity.
- R8: When the output register is selected, both read outputs are zero while reset is held and in the first cycle after reset. Reset does not clear the array. The registered output lags the unregistered value by one cycle.
- R9: When both ports write the same address on one edge, port A's write is applied and port B's whole write is discarded, including any lanes port A does not enable.
- R10: When the output register is not selected, each read output follows the array contents during the cycle right after the addressing edge, under any mix of reads, writes and collisions on both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | 9*LANES | Port A write word (data plus parity per lane) |
| a_we | input | 1 | Port A write enable |
| a_ben | input | LANES | Port A per-lane write enables |
| a_rdata | output | 9*LANES | Port A read word |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | 9*LANES | Port B write word (data plus parity per lane) |
| b_we | input | 1 | Port B write enable |
| b_ben | input | LANES | Port B per-lane write enables |
| b_rdata | output | 9*LANES | Port B read word |

## Verification
The hardest situation to reach is a mixed-port collision followed by a cycle with no writes and the same read address. Only that sequence separates the old-data result from the new-data result, and it must occur on both ports and in both collision settings. The stimulus builds it on purpose in both directions: A writes while B reads, then B writes while A reads. It then runs a long random phase with addresses limited to four locations. Same-address writes, partial lane enables and collisions therefore occur often, under a reference model updated on every edge.

// File: rtl/tdp_pkg.sv
// Package: shared constants and types for the two-port byte-lane RAM.
// Assumes 8 data bits plus 1 parity bit per lane.
package tdp_pkg;
    localparam int unsigned DATA_BITS = 8;
    localparam int unsigned LANE_W    = DATA_BITS + 1;

    // Result a reading port shows when the other port writes its address.
    typedef enum logic {
        COLL_OLD_DATA = 1'b0,
        COLL_UNDEF    = 1'b1
    } coll_mode_e;
endpackage

// File: rtl/tdp_lane_store.sv
// Module: storage for one 9-bit lane of every word, with two write ports
// and two read ports. Reads are combinational from registered addresses.
// Each port also captures the word at its input address before that edge's
// write. Assumes the caller has already applied the write priority.
module tdp_lane_store #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned WIDTH  = tdp_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              a_wen,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic [WIDTH-1:0]  a_wlane,
    input  logic              b_wen,
    input  logic [ADDR_W-1:0] b_waddr,
    input  logic [WIDTH-1:0]  b_wlane,
    input  logic [ADDR_W-1:0] a_raddr,
    input  logic [ADDR_W-1:0] b_raddr,
    output logic [WIDTH-1:0]  a_now,
    output logic [WIDTH-1:0]  b_now,
    output logic [WIDTH-1:0]  a_prev,
    output logic [WIDTH-1:0]  b_prev
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] cells [DEPTH];

    // Purpose: apply lane writes; A is written last so it wins any overlap.
    always_ff @(posedge clk) begin
        if (b_wen) cells[b_waddr] <= b_wlane;
        if (a_wen) cells[a_waddr] <= a_wlane;
    end

    // Purpose: keep the pre-write contents at each port's captured address.
    always_ff @(posedge clk) begin
        a_prev <= cells[a_waddr];
        b_prev <= cells[b_waddr];
    end

    assign a_now = cells[a_raddr];
    assign b_now = cells[b_raddr];
endmodule

// File: rtl/tdp_port_out.sv
// Module: read path of one port. Selects between the live array word and the
// collision result, then either drives it directly or through an output
// register that resets to zero. Assumes coll is already registered.
module tdp_port_out #(
    parameter int unsigned       WIDTH     = 36,
    parameter bit                OUT_REG   = 1'b1,
    parameter tdp_pkg::coll_mode_e COLL_MODE = tdp_pkg::COLL_OLD_DATA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] arr_word,
    input  logic [WIDTH-1:0] prev_word,
    input  logic             coll,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] coll_word;
    logic [WIDTH-1:0] pick;

    generate
        if (COLL_MODE == tdp_pkg::COLL_OLD_DATA) begin : g_old
            assign coll_word = prev_word;
        end else begin : g_undef
            logic [WIDTH-1:0] unused_prev;
            assign unused_prev = prev_word;
            assign coll_word   = {WIDTH{1'bx}};
        end
    endgenerate

    // Purpose: choose the collision result or the live array word.
    always_comb begin
        pick = coll ? coll_word : arr_word;
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [WIDTH-1:0] q;
            // Purpose: optional output register, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= pick;
            end
            assign rdata = q;
        end else begin : g_comb
            assign rdata = pick;
        end
    endgenerate
endmodule

// File: rtl/tdp_ram_bytepar.sv
// Module: true dual-port RAM on one clock. Words are built from 9-bit lanes
// (8 data + 1 parity) with per-lane write enables. Inputs act only on the
// rising edge. Port A wins a same-address double write. Assumes rst_n is
// synchronous and active low; reset does not clear the array.
module tdp_ram_bytepar #(
    parameter int unsigned         ADDR_W    = 4,
    parameter int unsigned         LANES     = 4,
    parameter bit                  OUT_REG   = 1'b1,
    parameter tdp_pkg::coll_mode_e COLL_MODE = tdp_pkg::COLL_OLD_DATA
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                a_addr,
    input  logic [LANES*tdp_pkg::LANE_W-1:0] a_wdata,
    input  logic                             a_we,
    input  logic [LANES-1:0]                 a_ben,
    output logic [LANES*tdp_pkg::LANE_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0]                b_addr,
    input  logic [LANES*tdp_pkg::LANE_W-1:0] b_wdata,
    input  logic                             b_we,
    input  logic [LANES-1:0]                 b_ben,
    output logic [LANES*tdp_pkg::LANE_W-1:0] b_rdata
);
    localparam int unsigned LW = tdp_pkg::LANE_W;
    localparam int unsigned W  = LANES * LW;

    logic              same_addr;
    logic              b_wr_ok;
    logic              a_coll_d, b_coll_d;
    logic              a_coll_q, b_coll_q;
    logic [ADDR_W-1:0] a_addr_q, b_addr_q;
    logic [W-1:0]      a_arr, b_arr, a_old, b_old;

    // Purpose: decide write priority and collision status from raw inputs.
    always_comb begin
        same_addr = (a_addr == b_addr);
        b_wr_ok   = b_we && !(a_we && same_addr);
        a_coll_d  = b_we && !a_we && same_addr;
        b_coll_d  = a_we && !b_we && same_addr;
    end

    // Purpose: capture read addresses and collision flags on the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_addr_q <= '0;
            b_addr_q <= '0;
            a_coll_q <= 1'b0;
            b_coll_q <= 1'b0;
        end else begin
            a_addr_q <= a_addr;
            b_addr_q <= b_addr;
            a_coll_q <= a_coll_d;
            b_coll_q <= b_coll_d;
        end
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            tdp_lane_store #(
                .ADDR_W (ADDR_W),
                .WIDTH  (LW)
            ) u_lane (
                .clk     (clk),
                .a_wen   (a_we && a_ben[l]),
                .a_waddr (a_addr),
                .a_wlane (a_wdata[l*LW +: LW]),
                .b_wen   (b_wr_ok && b_ben[l]),
                .b_waddr (b_addr),
                .b_wlane (b_wdata[l*LW +: LW]),
                .a_raddr (a_addr_q),
                .b_raddr (b_addr_q),
                .a_now   (a_arr[l*LW +: LW]),
                .b_now   (b_arr[l*LW +: LW]),
                .a_prev  (a_old[l*LW +: LW]),
                .b_prev  (b_old[l*LW +: LW])
            );
        end
    endgenerate

    tdp_port_out #(
        .WIDTH     (W),
        .OUT_REG   (OUT_REG),
        .COLL_MODE (COLL_MODE)
    ) u_out_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_word  (a_arr),
        .prev_word (a_old),
        .coll      (a_coll_q),
        .rdata     (a_rdata)
    );

    tdp_port_out #(
        .WIDTH     (W),
        .OUT_REG   (OUT_REG),
        .COLL_MODE (COLL_MODE)
    ) u_out_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_word  (b_arr),
        .prev_word (b_old),
        .coll      (b_coll_q),
        .rdata     (b_rdata)
    );
endmodule

// File: rtl/tdp_ram_checker.sv
// Module: timing properties of the two-port RAM, observed at its ports.
// The properties checked depend on whether the output register is present.
module tdp_ram_checker #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned LANES   = 4,
    parameter bit          OUT_REG = 1'b1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [ADDR_W-1:0]                a_addr,
    input logic [LANES*tdp_pkg::LANE_W-1:0] a_wdata,
    input logic                             a_we,
    input logic [LANES-1:0]                 a_ben,
    input logic [LANES*tdp_pkg::LANE_W-1:0] a_rdata,
    input logic [ADDR_W-1:0]                b_addr,
    input logic                             b_we,
    input logic [LANES*tdp_pkg::LANE_W-1:0] b_rdata
);
    generate
        if (OUT_REG) begin : g_reg
            a_r8_reset_zero: assert property (@(posedge clk)
                !rst_n |=> (a_rdata == '0 && b_rdata == '0));

            a_r8_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (a_we && &a_ben) |=> ##1 (a_rdata == $past(a_wdata, 2)));

            a_r9_a_wins_reg: assert property (@(posedge clk) disable iff (!rst_n)
                (a_we && &a_ben && b_we && a_addr == b_addr)
                |=> ##1 (b_rdata == $past(a_wdata, 2)));
        end else begin : g_comb
            a_r2_write_through: assert property (@(posedge clk) disable iff (!rst_n)
                (a_we && &a_ben) |=> (a_rdata == $past(a_wdata)));

            a_r9_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (a_we && &a_ben && b_we && a_addr == b_addr)
                |=> (b_rdata == $past(a_wdata)));

            a_r5_new_next: assert property (@(posedge clk) disable iff (!rst_n)
                (a_we && &a_ben && !b_we && a_addr == b_addr)
                ##1 (!a_we && !b_we && b_addr == $past(b_addr))
                |=> (b_rdata == $past(a_wdata, 2)));
        end
    endgenerate
endmodule

bind tdp_ram_bytepar tdp_ram_checker #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_we    (a_we),
    .a_ben   (a_ben),
    .a_rdata (a_rdata),
    .b_addr  (b_addr),
    .b_we    (b_we),
    .b_rdata (b_rdata)
);

// File: tb/tdp_ram_bytepar_test.sv
module tdp_ram_bytepar_test;
    localparam int AW = 4;
    localparam int LN = 4;
    localparam int W  = LN * 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [W-1:0]  a_wdata = '0, b_wdata = '0;
    logic          a_we = 1'b0, b_we = 1'b0;
    logic [LN-1:0] a_ben = '0, b_ben = '0;
    logic [W-1:0]  ua_rd, ub_rd, xa_rd, xb_rd;

    int    errors = 0;
    int    checks = 0;
    string tag = "R8";
    bit    done = 1'b0;

    tdp_ram_bytepar #(.ADDR_W(AW), .LANES(LN), .OUT_REG(1'b1),
                      .COLL_MODE(tdp_pkg::COLL_OLD_DATA)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_ben(a_ben), .a_rdata(ua_rd),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_ben(b_ben), .b_rdata(ub_rd));

    tdp_ram_bytepar #(.ADDR_W(AW), .LANES(LN), .OUT_REG(1'b0),
                      .COLL_MODE(tdp_pkg::COLL_UNDEF)) uut_x (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_ben(a_ben), .a_rdata(xa_rd),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_ben(b_ben), .b_rdata(xb_rd));

    // Reference model: word memory, per-lane known flags, per-port state.
    logic [W-1:0]  mem [DEPTH];
    bit   [LN-1:0] kn  [DEPTH];
    logic [AW-1:0] aq [2];
    logic [W-1:0]  cu [2], ru [2];
    bit            cu_ok [2], ru_ok [2], cx_ok [2];
    logic [W-1:0]  m_oa, m_ob;
    bit            m_oa_ok, m_ob_ok, m_ca, m_cb, m_same;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; kn[i] = '0; end
        for (int p = 0; p < 2; p++) begin
            aq[p] = '0; cu[p] = '0; ru[p] = '0;
            cu_ok[p] = 1'b0; ru_ok[p] = 1'b1; cx_ok[p] = 1'b0;
        end
    end

    always @(posedge clk) begin
        m_same  = (a_addr == b_addr);
        m_ca    = b_we && !a_we && m_same;
        m_cb    = a_we && !b_we && m_same;
        m_oa    = mem[a_addr]; m_oa_ok = &kn[a_addr];
        m_ob    = mem[b_addr]; m_ob_ok = &kn[b_addr];
        if (b_we && !(a_we && m_same))
            for (int l = 0; l < LN; l++)
                if (b_ben[l]) begin mem[b_addr][l*9 +: 9] = b_wdata[l*9 +: 9]; kn[b_addr][l] = 1'b1; end
        if (a_we)
            for (int l = 0; l < LN; l++)
                if (a_ben[l]) begin mem[a_addr][l*9 +: 9] = a_wdata[l*9 +: 9]; kn[a_addr][l] = 1'b1; end
        if (!rst_n) begin
            aq[0] = '0; aq[1] = '0; m_ca = 1'b0; m_cb = 1'b0;
            ru[0] = '0; ru[1] = '0; ru_ok[0] = 1'b1; ru_ok[1] = 1'b1;
        end else begin
            ru[0] = cu[0]; ru_ok[0] = cu_ok[0];
            ru[1] = cu[1]; ru_ok[1] = cu_ok[1];
            aq[0] = a_addr; aq[1] = b_addr;
        end
        cu[0] = m_ca ? m_oa : mem[aq[0]];  cu_ok[0] = m_ca ? m_oa_ok : &kn[aq[0]];
        cu[1] = m_cb ? m_ob : mem[aq[1]];  cu_ok[1] = m_cb ? m_ob_ok : &kn[aq[1]];
        cx_ok[0] = !m_ca && &kn[aq[0]];
        cx_ok[1] = !m_cb && &kn[aq[1]];
    end

    task automatic chk(input string who, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, who, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (ru_ok[0]) chk("reg/old port A", ua_rd, ru[0]);
            if (ru_ok[1]) chk("reg/old port B", ub_rd, ru[1]);
            if (cx_ok[0]) chk("comb/undef port A", xa_rd, cu[0]);
            if (cx_ok[1]) chk("comb/undef port B", xb_rd, cu[1]);
        end
    end

    task automatic step(input logic aw, input logic [AW-1:0] aa, input logic [W-1:0] ad,
                        input logic [LN-1:0] ab, input logic bw, input logic [AW-1:0] ba,
                        input logic [W-1:0] bd, input logic [LN-1:0] bb);
        @(posedge clk); #2;
        a_we = aw; a_addr = aa; a_wdata = ad; a_ben = ab;
        b_we = bw; b_addr = ba; b_wdata = bd; b_ben = bb;
    endtask

    function automatic logic [W-1:0] rnd();
        logic [63:0] t;
        t = {$urandom, $urandom};
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] parity_only(input logic [LN-1:0] sel);
        logic [W-1:0] v;
        v = '0;
        for (int l = 0; l < LN; l++) v[l*9 + 8] = sel[l];
        return v;
    endfunction

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
    end

    initial begin
        // R8: outputs held at zero by reset
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: fill every word through A while B trails one address behind
        tag = "R1";
        for (int i = 0; i < DEPTH; i++)
            step(1, i[AW-1:0], rnd(), '1, 0, AW'(i - 1), '0, '0);
        step(0, 0, '0, '0, 0, 15, '0, '0);
        step(0, 1, '0, '0, 0, 14, '0, '0);
        // R2: write-through on both ports
        tag = "R2";
        step(1, 3, rnd(), '1, 1, 7, rnd(), '1);
        step(1, 3, rnd(), '1, 1, 7, rnd(), '1);
        step(0, 3, '0, '0, 0, 7, '0, '0);
        // R6: partial lane writes
        tag = "R6";
        step(1, 5, rnd(), 4'b0101, 1, 9, rnd(), 4'b1000);
        step(1, 5, rnd(), 4'b0010, 0, 9, '0, '0);
        step(0, 5, '0, '0, 0, 9, '0, '0);
        // R7: parity bits stored verbatim
        tag = "R7";
        step(1, 2, parity_only(4'b1011), '1, 0, 2, '0, '0);
        step(0, 2, '0, '0, 1, 2, parity_only(4'b1111), 4'b0100);
        step(0, 2, '0, '0, 0, 2, '0, '0);
        // R3: A writes what B reads; R5: next cycle shows new word
        tag = "R3";
        step(1, 11, rnd(), '1, 0, 11, '0, '0);
        tag = "R5";
        step(0, 11, '0, '0, 0, 11, '0, '0);
        step(0, 11, '0, '0, 0, 11, '0, '0);
        // R4: B writes what A reads (undefined mode recovers afterwards)
        tag = "R4";
        step(0, 12, '0, '0, 1, 12, rnd(), 4'b0110);
        step(0, 12, '0, '0, 0, 12, '0, '0);
        step(0, 12, '0, '0, 0, 12, '0, '0);
        // R9: both ports write one address; A wins, B discarded entirely
        tag = "R9";
        step(1, 6, rnd(), '1, 1, 6, rnd(), '1);
        step(1, 6, rnd(), 4'b0001, 1, 6, rnd(), '1);
        step(0, 6, '0, '0, 0, 6, '0, '0);
        step(0, 6, '0, '0, 0, 6, '0, '0);
        // R8: reset mid-run zeroes the registered outputs, keeps the array
        tag = "R8";
        step(0, 6, '0, '0, 0, 5, '0, '0);
        #1 rst_n = 1'b0;
        step(0, 6, '0, '0, 0, 5, '0, '0);
        step(0, 6, '0, '0, 0, 5, '0, '0);
        #1 rst_n = 1'b1;
        step(0, 6, '0, '0, 0, 5, '0, '0);
        step(0, 6, '0, '0, 0, 5, '0, '0);
        // R10: random traffic over four addresses
        tag = "R10";
        for (int n = 0; n < 600; n++)
            step($urandom_range(0, 1), AW'($urandom_range(0, 3)), rnd(), LN'($urandom),
                 $urandom_range(0, 1), AW'($urandom_range(0, 3)), rnd(), LN'($urandom));
        step(0, 0, '0, '0, 0, 1, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 summary();
    end
endmodule